// File: doc/BRIEF.md
# Frame-Size-Adaptive Transmit/Receive FIFO Pair

This block holds the two data queues of a serial controller. One carries words the host wants to send, the other carries words that come back from the serial line. Each queue has 32 physical slots of 32 bits. How many of those slots are usable at a given moment depends on a large-queue enable input and on the programmed frame width in bits. Narrow frames get deeper queues, and wide frames get shallower ones.

The host side pushes into the transmit queue and pops from the receive queue. The shifter side pops from the transmit queue and pushes into the receive queue. Both queues report their occupancy as a 12-bit status vector. The vector has four flags per queue: full, one short of full, empty, and holding exactly one. It also carries a sticky receive-overflow bit. A one-cycle overflow pulse is provided as well, for an interrupt block that sits elsewhere. Whenever the usable depth changes, both queues are emptied.

Top module: `fifo_pair_adaptive`

## Requirements
- R1: After reset both queues hold nothing. The status vector reads 0x440, meaning only bit 6 (rx empty) and bit 10 (tx empty) are set. The overflow pulse and both read-data outputs are zero.
- R2: With `big_en` low, both queues have a usable depth of 4 entries.
- R3: With `big_en` high, the usable depth is 32 when `frame_bits` is 8 or less, 16 when it is 9 to 16, and 8 when it is 17 or more.
- R4: A transmit push while the transmit occupancy equals the usable depth is dropped. The stored contents and the count do not change.
- R5: The full flag (tx bit 8, rx bit 4) is set when the count equals the depth. Full-next (tx bit 9, rx bit 5) is set when the count equals depth minus one. Empty (tx bit 10, rx bit 6) is set when the count is zero. Empty-next (tx bit 11, rx bit 7) is set when the count is one.
- R6: A receive push while the receive queue is at the usable depth is dropped. It sets the sticky overflow flag (status bit 2) and raises `rx_ovf_pulse` for exactly one cycle, both in the cycle after the push.
- R7: A receive pop clears the overflow flag. A pop of an empty queue leaves the read pointer where it was, and read data is zero while a queue is empty.
- R8: Each queue returns words in the order they were accepted.
- R9: A change of the usable depth empties both queues in the next cycle. A change of `frame_bits` that leaves the depth the same keeps the contents.
- R10: A transmit pop of an empty queue has no effect on later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_en | input | 1 | Large-queue enable |
| frame_bits | input | 6 | Programmed frame width in bits |
| tx_push | input | 1 | Host writes a word to the transmit queue |
| tx_wdata | input | 32 | Transmit write data |
| tx_pop | input | 1 | Shifter takes the head of the transmit queue |
| tx_rdata | output | 32 | Head of the transmit queue, zero when empty |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_wdata | input | 32 | Received word |
| rx_pop | input | 1 | Host reads the receive queue |
| rx_rdata | output | 32 | Head of the receive queue, zero when empty |
| status | output | 12 | Occupancy flags and sticky overflow bit |
| rx_ovf_pulse | output | 1 | One-cycle pulse on a dropped receive word |

## Verification
The assertions watch every cycle. They check that neither count ever goes above the registered depth, that a push against a full transmit queue leaves the count unchanged, and that a push against a full receive queue raises the overflow bit. They also check that a depth change zeroes both counts and that a pop of an empty receive queue leaves its pointer where it was. The mapping from configuration to depth for each frame-width band, the first-in first-out ordering, and the absence of a dropped word in the data read back can only be shown by the bench scenarios. The same holds for a frame-width change that keeps the depth and the contents.

// File: rtl/fifo_pair_adaptive.sv
module fifo_pair_adaptive #(
  parameter int DW        = 32,
  parameter int PHYS      = 32,
  parameter int FSW       = 6,
  parameter int SMALL_DEP = 4,
  localparam int AW = $clog2(PHYS),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big_en,
  input  logic [FSW-1:0] frame_bits,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [11:0]   status,
  output logic          rx_ovf_pulse
);

  logic [CW-1:0] dep_sel, dep_q;
  always_comb begin
    if (!big_en)                      dep_sel = CW'(SMALL_DEP);
    else if (frame_bits <= FSW'(8))   dep_sel = CW'(PHYS);
    else if (frame_bits <= FSW'(16))  dep_sel = CW'(PHYS / 2);
    else                              dep_sel = CW'(PHYS / 4);
  end

  wire dep_chg = dep_sel != dep_q;

  logic [DW-1:0] tx_mem [PHYS];
  logic [DW-1:0] rx_mem [PHYS];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          ovf_q;

  wire tx_full  = tx_cnt == dep_q;
  wire rx_full  = rx_cnt == dep_q;
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;

  wire tx_wr = tx_push && !tx_full && !dep_chg;
  wire tx_rd = tx_pop && !tx_empty && !dep_chg;
  wire rx_wr = rx_push && !rx_full && !dep_chg;
  wire rx_rd = rx_pop && !rx_empty && !dep_chg;
  wire rx_drop = rx_push && rx_full && !dep_chg;

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;
    if (rx_wr) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dep_q <= CW'(SMALL_DEP);
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      ovf_q <= 1'b0;
      rx_ovf_pulse <= 1'b0;
    end else begin
      dep_q <= dep_sel;
      rx_ovf_pulse <= rx_drop;
      if (rx_drop)     ovf_q <= 1'b1;
      else if (rx_pop) ovf_q <= 1'b0;
      if (dep_chg) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (tx_wr) tx_wp <= tx_wp + 1'b1;
        if (tx_rd) tx_rp <= tx_rp + 1'b1;
        if (rx_wr) rx_wp <= rx_wp + 1'b1;
        if (rx_rd) rx_rp <= rx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_wr) - CW'(tx_rd);
        rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_rd);
      end
    end
  end

  assign tx_rdata = tx_empty ? '0 : tx_mem[tx_rp];
  assign rx_rdata = rx_empty ? '0 : rx_mem[rx_rp];

  assign status = {tx_cnt == CW'(1), tx_empty, tx_cnt == dep_q - 1'b1, tx_full,
                   rx_cnt == CW'(1), rx_empty, rx_cnt == dep_q - 1'b1, rx_full,
                   1'b0, ovf_q, 2'b00};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= dep_q && rx_cnt <= dep_q); // R2
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == dep_q && tx_push && !tx_pop && dep_sel == dep_q) |=> $stable(tx_cnt)); // R4
  AST_RX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == dep_q && rx_push && dep_sel == dep_q) |=> (status[2] && rx_ovf_pulse)); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && rx_pop && dep_sel == dep_q) |=> $stable(rx_rp)); // R7
  AST_DEPTH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_sel != dep_q) |=> (tx_cnt == '0 && rx_cnt == '0)); // R9

endmodule

// File: tb/fifo_pair_adaptive_tb.sv
module fifo_pair_adaptive_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, big_en = 1'b0;
  logic [5:0] frame_bits = 6'd8;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [31:0] tx_wdata = '0, rx_wdata = '0;
  logic [31:0] tx_rdata, rx_rdata;
  logic [11:0] status;
  logic rx_ovf_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fifo_pair_adaptive dut_i (.clk(clk), .rst_n(rst_n), .big_en(big_en), .frame_bits(frame_bits),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .status(status), .rx_ovf_pulse(rx_ovf_pulse));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic push_tx(logic [31:0] d); tx_push = 1; tx_wdata = d; step(); endtask
  task automatic push_rx(logic [31:0] d); rx_push = 1; rx_wdata = d; step(); endtask
  task automatic pop_tx(output logic [31:0] d); d = tx_rdata; tx_pop = 1; step(); endtask
  task automatic pop_rx(output logic [31:0] d); d = rx_rdata; rx_pop = 1; step(); endtask
  task automatic set_cfg(logic b, logic [5:0] f); big_en = b; frame_bits = f; step(); endtask

  task automatic t_reset();
    chk("R1 status", 32'(status), 32'h440);
    chk("R1 pulse", 32'(rx_ovf_pulse), 0);
    chk("R1 txdata", tx_rdata, 0);
    chk("R1 rxdata", rx_rdata, 0);
  endtask

  task automatic t_small_flags();
    logic [31:0] d;
    set_cfg(0, 6'd8);
    push_tx(32'hA0);
    chk("R5 tx empty-next", 32'(status[11:8]), 32'b1000);
    push_tx(32'hA1); push_tx(32'hA2);
    chk("R5 tx full-next", 32'(status[11:8]), 32'b0010);
    push_tx(32'hA3);
    chk("R2 tx full at 4", 32'(status[11:8]), 32'b0001);
    push_tx(32'hDEAD);
    chk("R4 still full", 32'(status[11:8]), 32'b0001);
    for (int i = 0; i < 4; i++) begin
      pop_tx(d);
      chk("R8 R4 tx order", d, 32'hA0 + 32'(i));
    end
    chk("R10 tx empty", 32'(status[11:8]), 32'b0100);
    chk("R10 tx rdata zero", tx_rdata, 0);
    pop_tx(d);
    push_tx(32'hB7);
    chk("R10 after empty pop", tx_rdata, 32'hB7);
    pop_tx(d);
  endtask

  task automatic t_rx_ovf();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) push_rx(32'hC0 + 32'(i));
    chk("R5 rx full", 32'(status[7:4]), 32'b0001);
    push_rx(32'hBAD);
    chk("R6 ovf bit", 32'(status[2]), 1);
    chk("R6 pulse", 32'(rx_ovf_pulse), 1);
    step();
    chk("R6 pulse one cycle", 32'(rx_ovf_pulse), 0);
    chk("R6 ovf sticky", 32'(status[2]), 1);
    pop_rx(d);
    chk("R8 rx head", d, 32'hC0);
    chk("R7 ovf cleared", 32'(status[2]), 0);
    chk("R7 full cleared", 32'(status[4]), 0);
    for (int i = 1; i < 4; i++) begin
      pop_rx(d);
      chk("R6 R8 rx order", d, 32'hC0 + 32'(i));
    end
    chk("R7 rx empty zero", rx_rdata, 0);
    pop_rx(d);
    chk("R7 empty pop data", d, 0);
    push_rx(32'hE1);
    chk("R7 pointer kept", rx_rdata, 32'hE1);
    chk("R5 rx empty-next", 32'(status[7:4]), 32'b1000);
    pop_rx(d);
  endtask

  task automatic fill_check(logic b, logic [5:0] f, int dep);
    set_cfg(b, f);
    chk("R9 flushed", 32'(status), 32'h440);
    for (int i = 0; i < dep - 1; i++) push_tx(32'(i));
    chk("R3 full-next", 32'(status[9:8]), 32'b10);
    push_tx(32'h55);
    chk("R3 full at depth", 32'(status[9:8]), 32'b01);
  endtask

  task automatic t_depths();
    fill_check(1, 6'd8, 32);
    fill_check(1, 6'd9, 16);
    fill_check(1, 6'd17, 8);
    fill_check(1, 6'd0, 32);
  endtask

  task automatic t_flush();
    set_cfg(0, 6'd8);
    push_tx(32'h1); push_rx(32'h2);
    set_cfg(0, 6'd20);
    chk("R9 same depth kept", tx_rdata, 32'h1);
    chk("R9 same depth rx kept", rx_rdata, 32'h2);
    set_cfg(1, 6'd20);
    chk("R9 flush both", 32'(status), 32'h440);
    chk("R9 tx data gone", tx_rdata, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_small_flags();
    t_rx_ovf();
    t_depths();
    t_flush();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule